// File: doc/BRIEF.md
# Power Converter Supervisory State Controller

This block is the supervisory sequencer for one regulated power converter. It folds the power-stage states (off, starting, stopping, fault shutdown) and the reference-generation states (idle, armed, running, cycling) into a single state register. Operator commands arrive as a valid-qualified code. Status inputs from the power stage and from the reference generator move the state along. The block decodes the state into enable, firing-block, circuit-configuration and ramp-down controls for the rest of the converter. It does not generate the reference, regulate current or drive the power stage itself.

Faults are gathered into a sticky register. A fault seen while the power stage reports that it is running takes the slow path, which waits for discharge before settling in the fault-off state. A fault seen while the stage is not running goes to fault-off at once. Fault-off can only be left through a reset command issued while the live fault vector is clear. A start supervision timer raises an internal fault if the power stage never reports ready. A standby state has four configurable behaviours. A slow-abort state asks for the reference to ramp down to its minimum before the converter stops.

Top module: `pc_supervisor`

## Requirements
- R1: After reset the state code is 0 (off), `pwr_enable` is 0, `fire_block` is 1, `fault_latch` is 0 and `cmd_reject` is 0. State codes: 0 off, 1 starting, 2 stopping, 3 fault-stopping, 4 fault-off, 5 slow-abort, 6 standby, 7 idle, 8 armed, 9 running, 10 to-cycling, 11 cycling, 12 polarity. Command codes: 1 on, 2 off, 3 standby, 4 slow-abort, 5 arm, 6 run, 7 cycle, 8 reset, 9 polarity flip.
- R2: A non-zero live fault in any state other than 3 or 4, with `pwr_running` high, moves the state to 3 on the next clock, and `pwr_enable` drops to 0.
- R3: State 3 is left only for state 4, and only on a clock where `pwr_discharged` is high. Every command given in state 3 is rejected.
- R4: A non-zero live fault in any state other than 3 or 4, with `pwr_running` low, moves the state straight to 4. In state 4 an on command is rejected and the state stays at 4.
- R5: `fault_latch` is the sticky OR of every live fault bit seen. It is cleared only by a reset command (8) in state 4 while `fault_in` is zero, and that command moves the state to 0. A reset command given while `fault_in` is non-zero is rejected.
- R6: In state 5 `ramp_down_req` is 1 and `pwr_enable` stays 1. The state moves to 2 on a clock where `ref_at_min` is high. State 2 moves to 0 on a clock where `pwr_discharged` is high.
- R7: In state 6, `standby_mode` selects the output: 0 sets only `ref_hold_min`, with firing not blocked; 1 sets `fire_block`; 2 sets `circuit_open` and `fire_block`; 3 sets `circuit_ground` and `fire_block`. Outside state 6 all three configuration outputs are 0.
- R8: The non-cycling sequence runs as follows: arm in 7 gives 8, run in 8 gives 9, and `func_end` in 9 returns to 7.
- R9: The cycling sequence runs as follows: cycle in 7 gives 10, `ref_at_min` in 10 gives 11, polarity flip in 11 gives 12, and `ref_at_min` in 12 returns to 11.
- R10: In state 1 a high `pwr_ready` moves the state to 7. If `pwr_ready` stays low for START_CYCLES clocks in state 1, bit FAULT_W-1 of the live fault vector is raised and the fault path of R2/R4 is taken, with that bit latched.
- R11: A valid command that is not legal in the current state leaves the state unchanged and produces `cmd_reject` high for exactly the one following cycle. A command given in a cycle where a fault is taken is dropped without a reject.
- R12: An off command in state 1 or in any of states 5 to 12 moves the state to 2, and `pwr_enable` is 0 in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (see R1) |
| fault_in | input | FAULT_W | Live fault vector |
| pwr_running | input | 1 | Power stage is delivering power |
| pwr_discharged | input | 1 | Power stage is disconnected and discharged |
| pwr_ready | input | 1 | Power stage has finished starting |
| ref_at_min | input | 1 | Reference has reached its minimum |
| func_end | input | 1 | Reference function has finished |
| standby_mode | input | 2 | Standby behaviour select (see R7) |
| state_code | output | 4 | Current state code |
| pwr_enable | output | 1 | Power stage enable |
| fire_block | output | 1 | Block converter firing |
| ref_hold_min | output | 1 | Hold the reference at minimum |
| circuit_open | output | 1 | Open the output circuit |
| circuit_ground | output | 1 | Ground the output circuit |
| ramp_down_req | output | 1 | Request a ramp of the reference to minimum |
| fault_latch | output | FAULT_W | Sticky fault register |
| cmd_reject | output | 1 | One-cycle pulse for a rejected command |

## Verification
The hardest situation to reach is the start timeout. The power stage has to withhold its ready flag for exactly START_CYCLES clocks, and the fault bit is raised by the block itself rather than driven at a port. The bench lowers START_CYCLES, holds `pwr_ready` low, and checks that the converter is still starting on the last permitted clock and has moved to fault-off with the top latch bit set on the next. A second hard case is a fault that arrives while the converter is already in the slow fault shutdown, followed by reset attempts while a fault is still live. The bench drives a second fault pattern during fault-stopping and then issues resets with and without a live fault.

// File: rtl/pcsm_pkg.sv
package pcsm_pkg;

    typedef enum logic [3:0] {
        PS_OFF        = 4'd0,
        PS_STARTING   = 4'd1,
        PS_STOPPING   = 4'd2,
        PS_FAULT_STOP = 4'd3,
        PS_FAULT_OFF  = 4'd4,
        PS_SLOW_ABORT = 4'd5,
        PS_STANDBY    = 4'd6,
        PS_IDLE       = 4'd7,
        PS_ARMED      = 4'd8,
        PS_RUNNING    = 4'd9,
        PS_TO_CYCLE   = 4'd10,
        PS_CYCLING    = 4'd11,
        PS_POLARITY   = 4'd12
    } pc_state_e;

    typedef enum logic [3:0] {
        CMD_NONE  = 4'd0,
        CMD_ON    = 4'd1,
        CMD_OFF   = 4'd2,
        CMD_STBY  = 4'd3,
        CMD_ABORT = 4'd4,
        CMD_ARM   = 4'd5,
        CMD_RUN   = 4'd6,
        CMD_CYCLE = 4'd7,
        CMD_RESET = 4'd8,
        CMD_FLIP  = 4'd9
    } pc_cmd_e;

    typedef enum logic [1:0] {
        SB_HOLD_MIN = 2'd0,
        SB_BLOCK    = 2'd1,
        SB_OPEN     = 2'd2,
        SB_GROUND   = 2'd3
    } sb_mode_e;

    typedef struct packed {
        pc_state_e state;
        logic      reject;
    } ctl_regs_t;

    function automatic logic is_powered(pc_state_e s);
        return (s == PS_STARTING) || (s >= PS_SLOW_ABORT && s <= PS_POLARITY);
    endfunction

endpackage

// File: rtl/pcsm_start_timer.sv
module pcsm_start_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic ready,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = '0;
        if (active) begin
            cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
        end
        expired = active && (cnt_q == LAST) && !ready;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R10: the counter never runs outside the starting phase
    a_r10_idle_counter: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0));

endmodule

// File: rtl/pcsm_fault_latch.sv
module pcsm_fault_latch #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] live,
    input  logic             clr,
    output logic [WIDTH-1:0] latched
);
    logic [WIDTH-1:0] latch_d, latch_q;

    always_comb begin
        latch_d = clr ? '0 : (latch_q | live);
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= latch_d;
    end

    assign latched = latch_q;

    a_r5_sticky_bits: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

    a_r5_captures_live: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((latch_q & $past(live)) == $past(live)));

endmodule

// File: rtl/pcsm_out_decode.sv
module pcsm_out_decode
    import pcsm_pkg::*;
(
    input  pc_state_e  state,
    input  logic [1:0] mode,
    output logic       pwr_enable,
    output logic       fire_block,
    output logic       ref_hold_min,
    output logic       circuit_open,
    output logic       circuit_ground,
    output logic       ramp_down_req
);
    logic in_stby;

    always_comb begin
        in_stby        = (state == PS_STANDBY);
        pwr_enable     = is_powered(state);
        ref_hold_min   = in_stby && (mode == SB_HOLD_MIN);
        circuit_open   = in_stby && (mode == SB_OPEN);
        circuit_ground = in_stby && (mode == SB_GROUND);
        fire_block     = !pwr_enable || (in_stby && (mode != SB_HOLD_MIN));
        ramp_down_req  = (state == PS_SLOW_ABORT);
    end

endmodule

// File: rtl/pc_supervisor.sv
module pc_supervisor
    import pcsm_pkg::*;
#(
    parameter int FAULT_W      = 16,
    parameter int START_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [3:0]         cmd_code,
    input  logic [FAULT_W-1:0] fault_in,
    input  logic               pwr_running,
    input  logic               pwr_discharged,
    input  logic               pwr_ready,
    input  logic               ref_at_min,
    input  logic               func_end,
    input  logic [1:0]         standby_mode,
    output logic [3:0]         state_code,
    output logic               pwr_enable,
    output logic               fire_block,
    output logic               ref_hold_min,
    output logic               circuit_open,
    output logic               circuit_ground,
    output logic               ramp_down_req,
    output logic [FAULT_W-1:0] fault_latch,
    output logic               cmd_reject
);
    localparam int TMO_BIT = FAULT_W - 1;

    ctl_regs_t          d, q;
    logic               tmo_hit;
    logic [FAULT_W-1:0] live;
    logic               acc, clr;
    logic c_on, c_off, c_stby, c_abort, c_arm, c_run, c_cycle, c_reset, c_flip;

    assign c_on    = cmd_valid && (cmd_code == CMD_ON);
    assign c_off   = cmd_valid && (cmd_code == CMD_OFF);
    assign c_stby  = cmd_valid && (cmd_code == CMD_STBY);
    assign c_abort = cmd_valid && (cmd_code == CMD_ABORT);
    assign c_arm   = cmd_valid && (cmd_code == CMD_ARM);
    assign c_run   = cmd_valid && (cmd_code == CMD_RUN);
    assign c_cycle = cmd_valid && (cmd_code == CMD_CYCLE);
    assign c_reset = cmd_valid && (cmd_code == CMD_RESET);
    assign c_flip  = cmd_valid && (cmd_code == CMD_FLIP);

    pcsm_start_timer #(.LIMIT(START_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (q.state == PS_STARTING),
        .ready   (pwr_ready),
        .expired (tmo_hit)
    );

    always_comb begin
        live          = fault_in;
        live[TMO_BIT] = fault_in[TMO_BIT] | tmo_hit;
    end

    always_comb begin
        d        = q;
        d.reject = 1'b0;
        acc      = 1'b0;
        clr      = 1'b0;
        if (q.state != PS_FAULT_STOP && q.state != PS_FAULT_OFF && (|live)) begin
            d.state = pwr_running ? PS_FAULT_STOP : PS_FAULT_OFF;
        end else begin
            case (q.state)
                PS_OFF: begin
                    if (c_on) begin d.state = PS_STARTING; acc = 1'b1; end
                end
                PS_STARTING: begin
                    if (c_off) begin d.state = PS_STOPPING; acc = 1'b1; end
                    else if (pwr_ready) d.state = PS_IDLE;
                end
                PS_STOPPING: begin
                    if (pwr_discharged) d.state = PS_OFF;
                end
                PS_FAULT_STOP: begin
                    if (pwr_discharged) d.state = PS_FAULT_OFF;
                end
                PS_FAULT_OFF: begin
                    if (c_reset && (fault_in == '0)) begin
                        d.state = PS_OFF; acc = 1'b1; clr = 1'b1;
                    end
                end
                PS_SLOW_ABORT, PS_STANDBY, PS_IDLE, PS_ARMED, PS_RUNNING,
                PS_TO_CYCLE, PS_CYCLING, PS_POLARITY: begin
                    if (c_off) begin
                        d.state = PS_STOPPING; acc = 1'b1;
                    end else if (c_abort && q.state != PS_SLOW_ABORT) begin
                        d.state = PS_SLOW_ABORT; acc = 1'b1;
                    end else begin
                        case (q.state)
                            PS_SLOW_ABORT: if (ref_at_min) d.state = PS_STOPPING;
                            PS_STANDBY:    if (c_on) begin d.state = PS_IDLE; acc = 1'b1; end
                            PS_IDLE: begin
                                if (c_arm)        begin d.state = PS_ARMED;    acc = 1'b1; end
                                else if (c_cycle) begin d.state = PS_TO_CYCLE; acc = 1'b1; end
                                else if (c_stby)  begin d.state = PS_STANDBY;  acc = 1'b1; end
                            end
                            PS_ARMED: begin
                                if (c_run)       begin d.state = PS_RUNNING; acc = 1'b1; end
                                else if (c_stby) begin d.state = PS_STANDBY; acc = 1'b1; end
                            end
                            PS_RUNNING:  if (func_end) d.state = PS_IDLE;
                            PS_TO_CYCLE: if (ref_at_min) d.state = PS_CYCLING;
                            PS_CYCLING: begin
                                if (c_flip)      begin d.state = PS_POLARITY; acc = 1'b1; end
                                else if (c_stby) begin d.state = PS_STANDBY;  acc = 1'b1; end
                            end
                            PS_POLARITY: if (ref_at_min) d.state = PS_CYCLING;
                            default: d.state = q.state;
                        endcase
                    end
                end
                default: d.state = PS_OFF;
            endcase
            d.reject = cmd_valid && !acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state  <= PS_OFF;
            q.reject <= 1'b0;
        end else begin
            q <= d;
        end
    end

    pcsm_fault_latch #(.WIDTH(FAULT_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .live    (live),
        .clr     (clr),
        .latched (fault_latch)
    );

    pcsm_out_decode u_dec (
        .state          (q.state),
        .mode           (standby_mode),
        .pwr_enable     (pwr_enable),
        .fire_block     (fire_block),
        .ref_hold_min   (ref_hold_min),
        .circuit_open   (circuit_open),
        .circuit_ground (circuit_ground),
        .ramp_down_req  (ramp_down_req)
    );

    assign state_code = q.state;
    assign cmd_reject = q.reject;

    a_r2_fault_running_stop: assert property (@(posedge clk) disable iff (rst)
        (q.state != PS_FAULT_STOP && q.state != PS_FAULT_OFF && (fault_in != '0) && pwr_running)
        |=> (state_code == 4'd3 && !pwr_enable));

    a_r3_wait_discharge: assert property (@(posedge clk) disable iff (rst)
        (q.state == PS_FAULT_STOP && !pwr_discharged) |=> (state_code == 4'd3));

    a_r4_no_start_from_fault: assert property (@(posedge clk) disable iff (rst)
        (q.state == PS_FAULT_OFF) |=> (state_code == 4'd4 || state_code == 4'd0));

    a_r5_reset_needs_clear: assert property (@(posedge clk) disable iff (rst)
        (q.state == PS_FAULT_OFF && fault_in != '0) |=> (state_code == 4'd4));

    a_r6_abort_holds: assert property (@(posedge clk) disable iff (rst)
        (q.state == PS_SLOW_ABORT && !ref_at_min && fault_in == '0 && !c_off)
        |=> (state_code == 4'd5 && ramp_down_req));

    a_r11_on_in_fault_rejected: assert property (@(posedge clk) disable iff (rst)
        (q.state == PS_FAULT_OFF && c_on) |=> cmd_reject);

endmodule

// File: tb/tb_pc_supervisor.sv
module tb_pc_supervisor;
    localparam int FW  = 16;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_code = 4'd0;
    logic [FW-1:0] fault_in = '0;
    logic          pwr_running = 1'b0;
    logic          pwr_discharged = 1'b1;
    logic          pwr_ready = 1'b0;
    logic          ref_at_min = 1'b0;
    logic          func_end = 1'b0;
    logic [1:0]    standby_mode = 2'd0;
    logic [3:0]    state_code;
    logic          pwr_enable, fire_block, ref_hold_min, circuit_open;
    logic          circuit_ground, ramp_down_req, cmd_reject;
    logic [FW-1:0] fault_latch;

    int n_chk = 0;
    int n_fail = 0;

    int            m_state = 0;
    logic [FW-1:0] m_latch = '0;
    logic          m_rej = 1'b0;
    int            m_cnt = 0;

    always #5 clk = ~clk;

    pc_supervisor #(.FAULT_W(FW), .START_CYCLES(LIM)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .fault_in(fault_in), .pwr_running(pwr_running),
        .pwr_discharged(pwr_discharged), .pwr_ready(pwr_ready),
        .ref_at_min(ref_at_min), .func_end(func_end),
        .standby_mode(standby_mode), .state_code(state_code),
        .pwr_enable(pwr_enable), .fire_block(fire_block),
        .ref_hold_min(ref_hold_min), .circuit_open(circuit_open),
        .circuit_ground(circuit_ground), .ramp_down_req(ramp_down_req),
        .fault_latch(fault_latch), .cmd_reject(cmd_reject)
    );

    function automatic bit cv(int c);
        return cmd_valid && (int'(cmd_code) == c);
    endfunction

    // Behavioural reference model, advanced on every clock edge
    always @(posedge clk) begin
        int ns;
        bit acc;
        bit clr;
        logic [FW-1:0] live;
        if (rst) begin
            m_state = 0; m_latch = '0; m_rej = 1'b0; m_cnt = 0;
        end else begin
            live = fault_in;
            if (m_state == 1 && m_cnt == LIM - 1 && !pwr_ready) live[FW-1] = 1'b1;
            ns = m_state; acc = 0; clr = 0;
            if (m_state != 3 && m_state != 4 && live != '0) begin
                ns = pwr_running ? 3 : 4;
                m_rej = 1'b0;
            end else begin
                if (m_state == 0) begin
                    if (cv(1)) begin ns = 1; acc = 1; end
                end else if (m_state == 1) begin
                    if (cv(2)) begin ns = 2; acc = 1; end
                    else if (pwr_ready) ns = 7;
                end else if (m_state == 2) begin
                    if (pwr_discharged) ns = 0;
                end else if (m_state == 3) begin
                    if (pwr_discharged) ns = 4;
                end else if (m_state == 4) begin
                    if (cv(8) && fault_in == '0) begin ns = 0; acc = 1; clr = 1; end
                end else begin
                    if (cv(2)) begin ns = 2; acc = 1; end
                    else if (cv(4) && m_state != 5) begin ns = 5; acc = 1; end
                    else if (m_state == 5 && ref_at_min) ns = 2;
                    else if (m_state == 6 && cv(1)) begin ns = 7; acc = 1; end
                    else if (m_state == 7 && cv(5)) begin ns = 8; acc = 1; end
                    else if (m_state == 7 && cv(7)) begin ns = 10; acc = 1; end
                    else if ((m_state == 7 || m_state == 8 || m_state == 11) && cv(3)) begin ns = 6; acc = 1; end
                    else if (m_state == 8 && cv(6)) begin ns = 9; acc = 1; end
                    else if (m_state == 9 && func_end) ns = 7;
                    else if ((m_state == 10 || m_state == 12) && ref_at_min) ns = 11;
                    else if (m_state == 11 && cv(9)) begin ns = 12; acc = 1; end
                end
                m_rej = cmd_valid && !acc;
            end
            if (m_state == 1) m_cnt = (m_cnt < LIM - 1) ? m_cnt + 1 : m_cnt;
            else              m_cnt = 0;
            m_latch = clr ? '0 : (m_latch | live);
            m_state = ns;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        bit en;
        bit sb;
        en = (m_state == 1) || (m_state >= 5 && m_state <= 12);
        sb = (m_state == 6);
        check("R8 model state", int'(state_code), m_state);
        check("R5 model latch", int'(fault_latch), int'(m_latch));
        check("R11 model reject", int'(cmd_reject), int'(m_rej));
        check("R12 model enable", int'(pwr_enable), int'(en));
        check("R6 model ramp", int'(ramp_down_req), int'(m_state == 5));
        check("R7 model hold", int'(ref_hold_min), int'(sb && standby_mode == 2'd0));
        check("R7 model open", int'(circuit_open), int'(sb && standby_mode == 2'd2));
        check("R7 model ground", int'(circuit_ground), int'(sb && standby_mode == 2'd3));
        check("R7 model block", int'(fire_block), int'(!en || (sb && standby_mode != 2'd0)));
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        if (!rst) compare_model();
    endtask

    task automatic send(int c);
        cmd_valid = 1'b1;
        cmd_code  = 4'(c);
        tick();
        cmd_valid = 1'b0;
        cmd_code  = 4'd0;
    endtask

    task automatic power_up();
        send(1);
        pwr_ready = 1'b1;
        tick();
        pwr_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 state", int'(state_code), 0);
        check("R1 enable", int'(pwr_enable), 0);
        check("R1 block", int'(fire_block), 1);
        check("R1 latch", int'(fault_latch), 0);
        check("R1 reject", int'(cmd_reject), 0);

        // R11 illegal command in off
        send(5);
        check("R11 reject pulse", int'(cmd_reject), 1);
        check("R11 state held", int'(state_code), 0);
        tick();
        check("R11 single cycle", int'(cmd_reject), 0);

        // R10 start then ready
        pwr_running = 1'b1;
        send(1);
        check("R10 starting", int'(state_code), 1);
        tick(); tick();
        pwr_ready = 1'b1;
        tick();
        pwr_ready = 1'b0;
        check("R10 ready to idle", int'(state_code), 7);

        // R8 non-cycling
        send(5);  check("R8 armed", int'(state_code), 8);
        send(6);  check("R8 running", int'(state_code), 9);
        send(5);  check("R11 arm while running", int'(cmd_reject), 1);
        func_end = 1'b1; tick(); func_end = 1'b0;
        check("R8 back to idle", int'(state_code), 7);

        // R9 cycling
        send(7);  check("R9 to cycling", int'(state_code), 10);
        tick();   check("R9 waits min", int'(state_code), 10);
        ref_at_min = 1'b1; tick(); ref_at_min = 1'b0;
        check("R9 cycling", int'(state_code), 11);
        send(9);  check("R9 polarity", int'(state_code), 12);
        ref_at_min = 1'b1; tick(); ref_at_min = 1'b0;
        check("R9 polarity done", int'(state_code), 11);

        // R7 standby modes
        send(3);  check("R7 standby", int'(state_code), 6);
        for (int m = 0; m < 4; m++) begin
            standby_mode = 2'(m);
            tick();
            check("R7 hold_min", int'(ref_hold_min), int'(m == 0));
            check("R7 fire_block", int'(fire_block), int'(m != 0));
            check("R7 open", int'(circuit_open), int'(m == 2));
            check("R7 ground", int'(circuit_ground), int'(m == 3));
        end
        standby_mode = 2'd0;
        send(1);  check("R7 standby exit", int'(state_code), 7);

        // R6 slow abort
        pwr_discharged = 1'b0;
        send(4);
        check("R6 abort state", int'(state_code), 5);
        check("R6 ramp request", int'(ramp_down_req), 1);
        check("R6 still enabled", int'(pwr_enable), 1);
        tick(); tick();
        check("R6 waits for min", int'(state_code), 5);
        ref_at_min = 1'b1; tick(); ref_at_min = 1'b0;
        check("R6 stopping", int'(state_code), 2);
        tick();   check("R6 stopping held", int'(state_code), 2);
        pwr_discharged = 1'b1; tick();
        check("R6 off", int'(state_code), 0);

        // R12 off from idle
        power_up();
        send(2);
        check("R12 stopping", int'(state_code), 2);
        check("R12 disabled", int'(pwr_enable), 0);
        tick();
        check("R12 off", int'(state_code), 0);

        // R2 / R3 fault while running
        power_up();
        pwr_running = 1'b1; pwr_discharged = 1'b0;
        fault_in = 16'h0005; tick(); fault_in = '0;
        check("R2 fault stopping", int'(state_code), 3);
        check("R2 disabled", int'(pwr_enable), 0);
        check("R5 latch first", int'(fault_latch), 16'h0005);
        fault_in = 16'h0100; tick(); fault_in = '0;
        check("R5 latch accumulate", int'(fault_latch), 16'h0105);
        send(8);
        check("R3 reset rejected", int'(cmd_reject), 1);
        check("R3 held", int'(state_code), 3);
        pwr_discharged = 1'b1; tick();
        check("R3 fault off", int'(state_code), 4);

        // R4 / R5 in fault off
        send(1);
        check("R4 on rejected", int'(cmd_reject), 1);
        check("R4 stays", int'(state_code), 4);
        fault_in = 16'h0002;
        send(8);
        check("R5 reset live rejected", int'(cmd_reject), 1);
        check("R5 stays fault", int'(state_code), 4);
        check("R5 latch live", int'(fault_latch), 16'h0107);
        fault_in = '0;
        send(8);
        check("R5 reset to off", int'(state_code), 0);
        check("R5 latch cleared", int'(fault_latch), 0);

        // R4 fault while not running
        pwr_running = 1'b0;
        fault_in = 16'h0800; tick(); fault_in = '0;
        check("R4 direct fault off", int'(state_code), 4);
        send(8);
        check("R4 recovered", int'(state_code), 0);

        // R10 start timeout
        send(1);
        repeat (LIM - 1) tick();
        check("R10 still starting", int'(state_code), 1);
        tick();
        check("R10 timeout fault", int'(state_code), 4);
        check("R10 timeout bit", int'(fault_latch), 16'h8000);
        send(8);
        check("R10 cleared", int'(state_code), 0);
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule